// File: doc/BRIEF.md
# LCD Raster Timing Generator

This block drives an LCD panel's scan timing. Two counters walk each frame: a pixel counter across a line, and a line counter down the frame. Every horizontal and vertical period opens with its sync pulse at count 0. The sync pulse is followed by the back porch, the visible region and the front porch. Comparators check the counters against programmed positions and produce horizontal sync, vertical sync and a display-enable qualifier. They also produce the byte address of the pixel the panel needs next from video memory, assuming two bytes per pixel.

The line currently being scanned is visible on `cur_line`. Three sticky status flags record the start of a frame (vertical sync start), the first visible line, and a programmable match line. Each flag has its own mask bit toward a single interrupt output.

All timing fields, the sync polarity and the line pitch are copied into a shadow set only when a frame begins, so reprogramming never tears a frame. The graphics enable input acts at once.

Top module: `lcd_raster_timer`

## Requirements
- R1: The pixel counter runs from 0 to `cfg_htotal` and then wraps to 0, so a line lasts `cfg_htotal`+1 clocks. Horizontal sync is asserted while the pixel count is below `cfg_hsync_end`.
- R2: `de` is high only when both of these hold. The pixel count lies in [`cfg_hact_start`, `cfg_hact_start`+`cfg_hact_len`). The line count lies in [`cfg_vact_start`, `cfg_vact_start`+`cfg_vact_len`).
- R3: The line counter advances when the pixel counter wraps, and wraps to 0 after line `cfg_vtotal`. Vertical sync is asserted on lines below `cfg_vsync_end`. `cur_line` shows the line count.
- R4: `cfg_sync_pol` bit 0 sets the hsync polarity and bit 1 sets the vsync polarity. A bit value of 1 makes that sync active high and 0 makes it active low.
- R5: While `cfg_gfx_en` is 0, `de` is low in the same cycle, with no frame delay.
- R6: Timing fields, polarity and line pitch written in mid-frame do not take effect until the first clock of the next frame.
- R7: `status` bit 0 is set when a new frame starts. Bit 1 is set when line `cfg_vact_start` begins. Bit 2 is set when line `cfg_irq_line` begins. Every bit stays set until a clock where the matching `stat_clr` bit is 1 (write-one-to-clear). A new event wins over a clear in the same clock.
- R8: `irq` is the OR of the `status` bits whose `irq_mask` bit is 0. A mask bit of 1 blocks its flag.
- R9: At each frame start the line start address becomes `cfg_fb_base`. After every visible line it advances by `cfg_line_bytes`. During `de`, `fetch_addr` is the line start plus 2×(pixel count − `cfg_hact_start`). Outside `de`, `fetch_addr` is the line start.
- R10: While `rst_n` is low, both counters, `cur_line`, `status`, `irq` and `de` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_gfx_en | input | 1 | Video memory access enable; 0 holds `de` low |
| cfg_hsync_end | input | CW | Pixel count at which hsync ends |
| cfg_hact_start | input | CW | First visible pixel count |
| cfg_htotal | input | CW | Last pixel count of a line |
| cfg_hact_len | input | CW | Visible pixels per line |
| cfg_vsync_end | input | CW | Line at which vsync ends |
| cfg_vact_start | input | CW | First visible line |
| cfg_vtotal | input | CW | Last line of a frame |
| cfg_vact_len | input | CW | Visible lines per frame |
| cfg_irq_line | input | CW | Line whose start sets status bit 2 |
| cfg_sync_pol | input | 2 | Sync polarity, bit 0 hsync, bit 1 vsync, 1 = active high |
| cfg_fb_base | input | AW | Byte address of the first visible pixel |
| cfg_line_bytes | input | AW | Byte pitch between visible lines |
| irq_mask | input | 3 | Per-flag interrupt mask, 1 = blocked |
| stat_clr | input | 3 | Write-one-to-clear strobes for `status` |
| hsync | output | 1 | Horizontal sync |
| vsync | output | 1 | Vertical sync |
| de | output | 1 | Display enable |
| cur_line | output | CW | Current line number |
| fetch_addr | output | AW | Video memory byte address for the current pixel |
| status | output | 3 | Sticky flags: 0 frame start, 1 display start, 2 line match |
| irq | output | 1 | Masked OR of the flags |

## Verification
The bench first walks a small 10×6 frame and checks positions on both sides of every sync, display-start and wrap boundary. A design with an off-by-one comparator would move an edge by one count. A design that steps the line address on a blank line, or fails to reload the base at frame start, would show a wrong `fetch_addr` on the second visible line or on the first line of the next frame.

Polarity and sync width are then changed in mid-frame. A design without shadowing would invert or widen hsync before the frame ends. The bench also turns `cfg_gfx_en` off and on while inside the visible window, to catch a design that delays it. Finally, it checks a clear strobe against the sticky flags, the mask path to `irq`, and a reset applied in mid-frame.

// File: rtl/lcd_rt_pkg.sv
package lcd_rt_pkg;
  // status flag positions, decoded by the interrupt logic
  localparam int ST_VS  = 0;
  localparam int ST_DS  = 1;
  localparam int ST_LN  = 2;
  localparam int NUM_ST = 3;
  // sync polarity bit positions
  localparam int POL_H  = 0;
  localparam int POL_V  = 1;
  // bytes per pixel (16-bit colour)
  localparam int PIX_BYTES = 2;
  // number of counter-width timing fields held in the shadow set
  localparam int NUM_TFIELD = 9;
endpackage

// File: rtl/lcd_rt_shadow.sv
module lcd_rt_shadow #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] q_r;
  logic [W-1:0] q_nxt;

  always_comb begin
    q_nxt = q_r;
    if (load) q_nxt = d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    q_r <= '0;
    else if (load) q_r <= q_nxt;
  end

  assign q = q_r;
endmodule

// File: rtl/lcd_rt_axis.sv
module lcd_rt_axis #(
  parameter int CW = 11
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          adv,
  input  logic [CW-1:0] total,
  input  logic [CW-1:0] sync_end,
  input  logic [CW-1:0] act_start,
  input  logic [CW-1:0] act_len,
  output logic [CW-1:0] cnt,
  output logic [CW-1:0] cnt_nxt,
  output logic          at_end,
  output logic          in_sync,
  output logic          in_act
);
  logic [CW-1:0] cnt_q;
  logic [CW-1:0] cnt_wrap;
  logic [CW:0]   act_stop;
  logic [CW:0]   cnt_ext;

  always_comb begin
    at_end   = (cnt_q == total);
    cnt_wrap = at_end ? '0 : cnt_q + CW'(1);
    act_stop = {1'b0, act_start} + {1'b0, act_len};
    cnt_ext  = {1'b0, cnt_q};
    in_sync  = (cnt_q < sync_end);
    in_act   = (cnt_q >= act_start) && (cnt_ext < act_stop);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   cnt_q <= '0;
    else if (adv) cnt_q <= cnt_wrap;
  end

  assign cnt     = cnt_q;
  assign cnt_nxt = cnt_wrap;
endmodule

// File: rtl/lcd_rt_status.sv
module lcd_rt_status #(
  parameter int N = 3
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] evt,
  input  logic [N-1:0] clr,
  input  logic [N-1:0] mask,
  output logic [N-1:0] flags,
  output logic         irq
);
  logic [N-1:0] st_q;
  logic [N-1:0] st_nxt;

  for (genvar gi = 0; gi < N; gi++) begin : g_flag
    assign st_nxt[gi] = evt[gi] | (st_q[gi] & ~clr[gi]);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) st_q <= '0;
    else        st_q <= st_nxt;
  end

  assign flags = st_q;
  assign irq   = |(st_q & ~mask);
endmodule

// File: rtl/lcd_rt_fetch.sv
module lcd_rt_fetch #(
  parameter int CW        = 11,
  parameter int AW        = 20,
  parameter int PIX_BYTES = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic [AW-1:0] base,
  input  logic          step_en,
  input  logic [AW-1:0] step,
  input  logic          de,
  input  logic [CW-1:0] hcnt,
  input  logic [CW-1:0] hstart,
  output logic [AW-1:0] addr
);
  logic [AW-1:0] line_q;
  logic [AW-1:0] line_nxt;
  logic [AW-1:0] pix_off;
  logic          line_en;

  always_comb begin
    line_en  = load | step_en;
    line_nxt = load ? base : line_q + step;
    pix_off  = de ? AW'(hcnt - hstart) : '0;
    addr     = line_q + pix_off * AW'(PIX_BYTES);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       line_q <= '0;
    else if (line_en) line_q <= line_nxt;
  end
endmodule

// File: rtl/lcd_raster_timer.sv
module lcd_raster_timer
  import lcd_rt_pkg::*;
#(
  parameter int CW = 11,
  parameter int AW = 20
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cfg_gfx_en,
  input  logic [CW-1:0] cfg_hsync_end,
  input  logic [CW-1:0] cfg_hact_start,
  input  logic [CW-1:0] cfg_htotal,
  input  logic [CW-1:0] cfg_hact_len,
  input  logic [CW-1:0] cfg_vsync_end,
  input  logic [CW-1:0] cfg_vact_start,
  input  logic [CW-1:0] cfg_vtotal,
  input  logic [CW-1:0] cfg_vact_len,
  input  logic [CW-1:0] cfg_irq_line,
  input  logic [1:0]    cfg_sync_pol,
  input  logic [AW-1:0] cfg_fb_base,
  input  logic [AW-1:0] cfg_line_bytes,
  input  logic [2:0]    irq_mask,
  input  logic [2:0]    stat_clr,
  output logic          hsync,
  output logic          vsync,
  output logic          de,
  output logic [CW-1:0] cur_line,
  output logic [AW-1:0] fetch_addr,
  output logic [2:0]    status,
  output logic          irq
);
  localparam int SHW = NUM_TFIELD * CW + 2 + AW;

  // shadowed configuration
  logic [SHW-1:0] cfg_bus;
  logic [SHW-1:0] sh_bus;
  logic [CW-1:0]  sh_hse, sh_hds, sh_ht, sh_hnp;
  logic [CW-1:0]  sh_vse, sh_vds, sh_vt, sh_vnp, sh_iln;
  logic [1:0]     sh_pol;
  logic [AW-1:0]  sh_pitch;

  // first clock after reset loads the shadow set
  logic prime_q;
  logic sh_load;

  // counter results
  logic [CW-1:0] h_cnt, h_nxt, v_cnt, v_nxt;
  logic          h_end, h_sync, h_act;
  logic          v_end, v_sync, v_act;
  logic          frame_end;
  logic [NUM_ST-1:0] evt;

  assign cfg_bus = {cfg_line_bytes, cfg_sync_pol, cfg_irq_line, cfg_vact_len,
                    cfg_vtotal, cfg_vact_start, cfg_vsync_end, cfg_hact_len,
                    cfg_htotal, cfg_hact_start, cfg_hsync_end};
  assign {sh_pitch, sh_pol, sh_iln, sh_vnp, sh_vt, sh_vds, sh_vse, sh_hnp,
          sh_ht, sh_hds, sh_hse} = sh_bus;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prime_q <= 1'b1;
    else        prime_q <= 1'b0;
  end

  assign frame_end = h_end & v_end;
  assign sh_load   = prime_q | frame_end;

  lcd_rt_shadow #(.W(SHW)) u_shadow (
    .clk   (clk),
    .rst_n (rst_n),
    .load  (sh_load),
    .d     (cfg_bus),
    .q     (sh_bus)
  );

  lcd_rt_axis #(.CW(CW)) u_haxis (
    .clk       (clk),
    .rst_n     (rst_n),
    .adv       (1'b1),
    .total     (sh_ht),
    .sync_end  (sh_hse),
    .act_start (sh_hds),
    .act_len   (sh_hnp),
    .cnt       (h_cnt),
    .cnt_nxt   (h_nxt),
    .at_end    (h_end),
    .in_sync   (h_sync),
    .in_act    (h_act)
  );

  lcd_rt_axis #(.CW(CW)) u_vaxis (
    .clk       (clk),
    .rst_n     (rst_n),
    .adv       (h_end),
    .total     (sh_vt),
    .sync_end  (sh_vse),
    .act_start (sh_vds),
    .act_len   (sh_vnp),
    .cnt       (v_cnt),
    .cnt_nxt   (v_nxt),
    .at_end    (v_end),
    .in_sync   (v_sync),
    .in_act    (v_act)
  );

  always_comb begin
    evt         = '0;
    evt[ST_VS]  = frame_end & ~prime_q;
    evt[ST_DS]  = h_end & (v_nxt == sh_vds) & ~prime_q;
    evt[ST_LN]  = h_end & (v_nxt == sh_iln) & ~prime_q;
  end

  lcd_rt_status #(.N(NUM_ST)) u_status (
    .clk   (clk),
    .rst_n (rst_n),
    .evt   (evt),
    .clr   (stat_clr),
    .mask  (irq_mask),
    .flags (status),
    .irq   (irq)
  );

  assign de       = cfg_gfx_en & h_act & v_act;
  assign hsync    = sh_pol[POL_H] ? h_sync : ~h_sync;
  assign vsync    = sh_pol[POL_V] ? v_sync : ~v_sync;
  assign cur_line = v_cnt;

  lcd_rt_fetch #(.CW(CW), .AW(AW), .PIX_BYTES(PIX_BYTES)) u_fetch (
    .clk     (clk),
    .rst_n   (rst_n),
    .load    (sh_load),
    .base    (cfg_fb_base),
    .step_en (h_end & v_act),
    .step    (sh_pitch),
    .de      (de),
    .hcnt    (h_cnt),
    .hstart  (sh_hds),
    .addr    (fetch_addr)
  );
endmodule

// File: rtl/lcd_raster_timer_chk.sv
module lcd_raster_timer_chk #(
  parameter int CW  = 11,
  parameter int SHW = 8
) (
  input logic           clk,
  input logic           rst_n,
  input logic [CW-1:0]  hcnt,
  input logic [CW-1:0]  sh_ht,
  input logic [CW-1:0]  sh_vds,
  input logic [SHW-1:0] sh_bus,
  input logic           sh_load,
  input logic [CW-1:0]  cur_line,
  input logic           de,
  input logic [2:0]     status,
  input logic [2:0]     stat_clr,
  input logic           irq
);
  AST_HCNT_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    hcnt <= sh_ht); // R1

  AST_DE_AFTER_VSTART: assert property (@(posedge clk) disable iff (!rst_n)
    de |-> (cur_line >= sh_vds)); // R2

  AST_LINE_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (cur_line != $past(cur_line)) |-> ((cur_line == $past(cur_line) + CW'(1)) || (cur_line == '0))); // R3

  AST_SHADOW_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(sh_load) |-> $stable(sh_bus)); // R6

  AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (($past(status) & ~$past(stat_clr) & ~status) == 3'b000)); // R7

  AST_IRQ_NEEDS_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> (status != 3'b000)); // R8
endmodule

bind lcd_raster_timer lcd_raster_timer_chk #(.CW(CW), .SHW(SHW)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .hcnt     (h_cnt),
  .sh_ht    (sh_ht),
  .sh_vds   (sh_vds),
  .sh_bus   (sh_bus),
  .sh_load  (sh_load),
  .cur_line (cur_line),
  .de       (de),
  .status   (status),
  .stat_clr (stat_clr),
  .irq      (irq)
);

// File: tb/lcd_raster_timer_tb.sv
module lcd_raster_timer_tb;
  localparam int CW = 11;
  localparam int AW = 20;

  logic          clk;
  logic          rst_n;
  logic          cfg_gfx_en;
  logic [CW-1:0] cfg_hsync_end, cfg_hact_start, cfg_htotal, cfg_hact_len;
  logic [CW-1:0] cfg_vsync_end, cfg_vact_start, cfg_vtotal, cfg_vact_len, cfg_irq_line;
  logic [1:0]    cfg_sync_pol;
  logic [AW-1:0] cfg_fb_base, cfg_line_bytes;
  logic [2:0]    irq_mask, stat_clr;
  logic          hsync, vsync, de, irq;
  logic [CW-1:0] cur_line;
  logic [AW-1:0] fetch_addr;
  logic [2:0]    status;

  int n_run  = 0;
  int n_fail = 0;
  int ecount;

  lcd_raster_timer #(.CW(CW), .AW(AW)) u_dut (
    .clk(clk), .rst_n(rst_n), .cfg_gfx_en(cfg_gfx_en),
    .cfg_hsync_end(cfg_hsync_end), .cfg_hact_start(cfg_hact_start),
    .cfg_htotal(cfg_htotal), .cfg_hact_len(cfg_hact_len),
    .cfg_vsync_end(cfg_vsync_end), .cfg_vact_start(cfg_vact_start),
    .cfg_vtotal(cfg_vtotal), .cfg_vact_len(cfg_vact_len),
    .cfg_irq_line(cfg_irq_line), .cfg_sync_pol(cfg_sync_pol),
    .cfg_fb_base(cfg_fb_base), .cfg_line_bytes(cfg_line_bytes),
    .irq_mask(irq_mask), .stat_clr(stat_clr),
    .hsync(hsync), .vsync(vsync), .de(de), .cur_line(cur_line),
    .fetch_addr(fetch_addr), .status(status), .irq(irq)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  // clocks since reset release; position in the raster is ecount-1
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) ecount <= 0;
    else        ecount <= ecount + 1;
  end

  typedef struct packed {
    int         pos;
    logic       hs;
    logic       vs;
    logic       de;
    logic [10:0] line;
    logic [19:0] fa;
    logic [2:0] st;
  } vec_t;

  // frame: 10 pixels x 6 lines, hsync h0-1, vsync v0, visible h3-6 on v2-3
  localparam vec_t TBL [12] = '{
    '{0,  1'b1, 1'b1, 1'b0, 11'd0, 20'h100, 3'b000},
    '{1,  1'b1, 1'b1, 1'b0, 11'd0, 20'h100, 3'b000},
    '{2,  1'b0, 1'b1, 1'b0, 11'd0, 20'h100, 3'b000},
    '{13, 1'b0, 1'b0, 1'b0, 11'd1, 20'h100, 3'b000},
    '{23, 1'b0, 1'b0, 1'b1, 11'd2, 20'h100, 3'b010},
    '{26, 1'b0, 1'b0, 1'b1, 11'd2, 20'h106, 3'b010},
    '{27, 1'b0, 1'b0, 1'b0, 11'd2, 20'h100, 3'b010},
    '{33, 1'b0, 1'b0, 1'b1, 11'd3, 20'h140, 3'b010},
    '{35, 1'b0, 1'b0, 1'b1, 11'd3, 20'h144, 3'b010},
    '{43, 1'b0, 1'b0, 1'b0, 11'd4, 20'h180, 3'b110},
    '{59, 1'b0, 1'b0, 1'b0, 11'd5, 20'h180, 3'b110},
    '{70, 1'b1, 1'b0, 1'b0, 11'd1, 20'h100, 3'b111}
  };

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h at pos %0d", tag, act, exp, ecount - 1);
    end
  endtask

  task automatic goto(input int p);
    while (ecount - 1 != p) @(negedge clk);
  endtask

  task automatic base_cfg();
    cfg_gfx_en = 1'b1;
    cfg_hsync_end = 11'd2; cfg_hact_start = 11'd3; cfg_htotal = 11'd9; cfg_hact_len = 11'd4;
    cfg_vsync_end = 11'd1; cfg_vact_start = 11'd2; cfg_vtotal = 11'd5; cfg_vact_len = 11'd2;
    cfg_irq_line = 11'd4; cfg_sync_pol = 2'b11;
    cfg_fb_base = 20'h100; cfg_line_bytes = 20'h40;
    irq_mask = 3'b111; stat_clr = 3'b000;
  endtask

  initial begin
    #4000000;
    n_run++;
    n_fail++;
    $display("FAIL watchdog expired");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    rst_n = 1'b0;
    base_cfg();
    repeat (3) @(negedge clk);
    // R10: state under reset
    chk("R10 de", de, 0);
    chk("R10 status", status, 0);
    chk("R10 irq", irq, 0);
    chk("R10 cur_line", cur_line, 0);
    rst_n = 1'b1;

    // table walk over one frame and into the next
    for (int i = 0; i < 12; i++) begin
      goto(TBL[i].pos);
      chk("R1 hsync", hsync, TBL[i].hs);
      chk("R3 vsync", vsync, TBL[i].vs);
      chk("R2 de", de, TBL[i].de);
      chk("R3 cur_line", cur_line, TBL[i].line);
      chk("R9 fetch_addr", fetch_addr, TBL[i].fa);
      chk("R7 status", status, TBL[i].st);
      chk("R8 irq masked", irq, 0);
    end

    // R8: unmask frame-start flag, then mask again
    irq_mask = 3'b110; #1;
    chk("R8 irq unmasked", irq, 1);
    irq_mask = 3'b111; #1;
    chk("R8 irq remasked", irq, 0);

    // R7: clear only bit 0
    stat_clr = 3'b001;
    @(negedge clk);
    stat_clr = 3'b000;
    chk("R7 w1c", status, 3'b110);

    // R5: graphics enable gates de at once
    goto(82);
    cfg_gfx_en = 1'b0;
    goto(83);
    chk("R5 de off", de, 0);
    cfg_gfx_en = 1'b1; #1;
    chk("R5 de on", de, 1);

    // R6 / R4: mid-frame change of polarity and sync width
    goto(85);
    cfg_sync_pol = 2'b00;
    cfg_hsync_end = 11'd3;
    goto(90);
    chk("R6 old pol hsync", hsync, 1);
    goto(92);
    chk("R6 old width hsync", hsync, 0);
    goto(120);
    chk("R4 hsync low active", hsync, 0);
    chk("R4 vsync low active", vsync, 0);
    goto(122);
    chk("R6 new width hsync", hsync, 0);
    goto(123);
    chk("R4 hsync idle high", hsync, 1);
    goto(130);
    chk("R4 vsync idle high", vsync, 1);

    // R10: reset in mid-frame
    goto(131);
    rst_n = 1'b0; #1;
    chk("R10 mid status", status, 0);
    chk("R10 mid irq", irq, 0);
    chk("R10 mid de", de, 0);
    chk("R10 mid cur_line", cur_line, 0);
    base_cfg();
    @(negedge clk);
    rst_n = 1'b1;
    goto(1);
    chk("R1 hsync after reset", hsync, 1);
    goto(2);
    chk("R1 hsync end", hsync, 0);
    goto(9);
    chk("R1 last pixel line", cur_line, 0);
    goto(10);
    chk("R1 wrap hsync", hsync, 1);
    chk("R3 line advance", cur_line, 1);

    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule